// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps the stored charge of a DDR memory alive on behalf of the controller that sits in front of it. A prescaled tick drives an interval counter, and each time the interval runs out the block earns one refresh credit. When it holds credit it raises a request towards the controller's command arbiter. Once the arbiter grants, meaning it has stopped its own traffic, the block closes any open banks with a precharge-all command. It then sends one refresh command per credit, spaced by the refresh cycle time.

Credit may build up while the arbiter stays busy, and the scheduler catches up in one burst when it gets the grant. When the owed count reaches its ceiling, the block raises a force line that obliges the arbiter to grant. The block also handles self-refresh. It pays its debt, enters self-refresh by sending the refresh command with clock-enable low, and leaves when the request drops. After leaving it releases non-read traffic before read traffic. After reset it keeps clock-enable low and blocks all traffic until the power-up wait has run out. It then raises clock-enable and asks for a first refresh.

Every timing count comes from a time parameter and the clock period. The refresh cycle, precharge and power-up waits are rounded up. The refresh interval is rounded down so that the average rate is never too slow.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset, `cke` is low, `busy` and `rd_blocked` are high and `cmd_code` is 0 (no command). `cke` rises exactly PWR_CYC cycles after reset release, which is 10000 cycles for 200 µs at a 20 ns clock.
- R2: In the cycle that `cke` rises after power-up, the block holds one refresh credit and raises `arb_req`.
- R3: While the block is awake, a refresh becomes due every TICK_DIV × REFI_TICKS cycles, which is 390 cycles for 7.8 µs. Each due adds one credit, and `arb_req` rises in the cycle after an idle block gains credit. The interval restarts from zero when the block leaves self-refresh.
- R4: Commands appear on `cmd_code` only while `arb_gnt` is high. The codes are 0 for none, 1 for precharge-all, 2 for refresh and 3 for self-refresh entry. No command is issued that the requirements do not call for.
- R5: If `banks_idle` is low when the grant arrives, precharge-all (code 1) is issued in the next cycle. The first refresh follows RP_CYC cycles later, which is 2 cycles.
- R6: Consecutive refreshes are RFC_CYC cycles apart, which is 4 cycles for 72 ns. All owed refreshes are issued back to back in one grant, and `arb_req` drops RFC_CYC cycles after the last one.
- R7: `arb_force` is high exactly while the owed count equals MAX_OWED (8). The count saturates there.
- R8: When `sr_req` is high and no credit is left, self-refresh entry (code 3) is issued with `cke` low. Entering self-refresh clears all credit.
- R9: Each new level of `cke` is held for at least two cycles.
- R10: One cycle after `sr_req` drops, `cke` rises with no command. `busy` clears SRX_NONRD_CYC (12) cycles after the rise, and `rd_blocked` clears SRX_RD_CYC (200) cycles after the rise.
- R11: `busy` is high from the grant through the end of the last refresh cycle time. It is low while the block is idle or still waiting for a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| arb_gnt | input | 1 | Arbiter has stopped traffic and hands the command bus over; held while `arb_req` is high |
| banks_idle | input | 1 | No bank is open |
| sr_req | input | 1 | Request to stay in self-refresh while high |
| arb_req | output | 1 | Request for the command bus |
| arb_force | output | 1 | Credit at its ceiling; the arbiter must grant |
| cmd_code | output | 2 | 0 none, 1 precharge-all, 2 refresh, 3 self-refresh entry |
| cke | output | 1 | Clock-enable to the memory |
| busy | output | 1 | All new traffic must be held off |
| rd_blocked | output | 1 | Read commands must be held off |

## Verification
A miscounted interval, prescaler or power-up timer shows up as a shifted `cke` rise or a shifted `arb_req` rise, and the bench pins both to the exact cycle. A credit counter that drops or keeps one count gives the wrong number of refreshes in the catch-up burst. It also causes a stray request right after self-refresh exit, a few hundred cycles before the next due. A wrong gap timer moves every following command in the stream, and the scoreboard matches each command against its exact code and cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PALL = 2'd1,
    CMD_REFR = 2'd2,
    CMD_SREN = 2'd3
  } dcmd_t;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_PREW,
    ST_REF,
    ST_RFC,
    ST_SRE,
    ST_SR,
    ST_SRX
  } st_t;

  // round a duration up to whole clocks (minimum waits)
  function automatic int cyc_ceil(longint dur_ps, longint clk_ps);
    return int'((dur_ps + clk_ps - 1) / clk_ps);
  endfunction

  // round a duration down to whole units (maximum intervals)
  function automatic int cyc_floor(longint dur_ps, longint unit_ps);
    return int'(dur_ps / unit_ps);
  endfunction

  function automatic int at_least(int v, int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic dcmd_t cmd_of(st_t s);
    case (s)
      ST_PRE:  return CMD_PALL;
      ST_REF:  return CMD_REFR;
      ST_SRE:  return CMD_SREN;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic clock_stopped(st_t s);
    return (s == ST_PWR) || (s == ST_SRE) || (s == ST_SR);
  endfunction

  function automatic logic owns_bus(st_t s);
    return (s == ST_REQ) || (s == ST_PRE) || (s == ST_PREW) || (s == ST_REF) ||
           (s == ST_RFC) || (s == ST_SRE) || (s == ST_SR);
  endfunction

  function automatic logic hard_hold(st_t s);
    return (s == ST_PWR) || (s == ST_PRE) || (s == ST_PREW) || (s == ST_REF) ||
           (s == ST_RFC) || (s == ST_SRE) || (s == ST_SR);
  endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= W'(RST_VAL);
    else if (ld)          cnt <= ld_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/refsched_tick.sv
module refsched_tick
  import refsched_pkg::*;
#(
  parameter int DIV   = 10,
  parameter int TICKS = 39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic due
);

  localparam int PW     = at_least($clog2(DIV), 1);
  localparam int IW     = at_least($clog2(TICKS), 1);
  localparam int PERIOD = DIV * TICKS;
  localparam int GW     = $clog2(PERIOD + 1);

  logic [PW-1:0] pre_q;
  logic [IW-1:0] ival_q;
  logic          tick;

  assign tick = en && (pre_q == PW'(DIV - 1));
  assign due  = tick && (ival_q == IW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ival_q <= '0;
    end else if (!en) begin
      pre_q  <= '0;
      ival_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) ival_q <= (ival_q == IW'(TICKS - 1)) ? '0 : ival_q + 1'b1;
    end
  end

  // independent cycle count since enable or the previous due
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (!en)    gap_q <= '0;
    else if (due)    gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  // R3
  due_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due |-> (gap_q == GW'(PERIOD - 1)));

endmodule

// File: rtl/refsched_credit.sv
module refsched_credit #(
  parameter int MAXC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        earn,
  input  logic                        spend,
  input  logic                        wipe,
  input  logic                        seed,
  output logic [$clog2(MAXC+1)-1:0]   owed,
  output logic                        full
);

  localparam int CW = $clog2(MAXC + 1);

  logic can_up, can_dn;
  assign can_up = earn && (owed != CW'(MAXC));
  assign can_dn = spend && (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owed <= '0;
    else if (wipe)   owed <= '0;
    else if (seed)   owed <= CW'(1);
    else begin
      case ({can_up, can_dn})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign full = (owed == CW'(MAXC));

  // R7
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= CW'(MAXC));

  // R6
  spend_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spend |-> (owed != '0));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int CLK_PS        = 20000,
  parameter int REFI_PS       = 7800000,
  parameter int RFC_PS        = 72000,
  parameter int RP_PS         = 18000,
  parameter int PWRUP_PS      = 200000000,
  parameter int TICK_DIV      = 10,
  parameter int SRX_NONRD_CYC = 12,
  parameter int SRX_RD_CYC    = 200,
  parameter int MAX_OWED      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arb_gnt,
  input  logic       banks_idle,
  input  logic       sr_req,
  output logic       arb_req,
  output logic       arb_force,
  output logic [1:0] cmd_code,
  output logic       cke,
  output logic       busy,
  output logic       rd_blocked
);

  localparam int RFC_CYC    = at_least(cyc_ceil(RFC_PS, CLK_PS), 2);
  localparam int RP_CYC     = at_least(cyc_ceil(RP_PS, CLK_PS), 2);
  localparam int PWR_CYC    = at_least(cyc_ceil(PWRUP_PS, CLK_PS), 2);
  localparam int REFI_TICKS = at_least(cyc_floor(REFI_PS, longint'(CLK_PS) * TICK_DIV), 1);
  localparam int RD_CYC     = at_least(SRX_RD_CYC, at_least(SRX_NONRD_CYC, 2));
  localparam int TMR_MAX    = max2(max2(PWR_CYC, RD_CYC), max2(RFC_CYC, RP_CYC));
  localparam int TW         = $clog2(TMR_MAX + 1);
  localparam int CW         = $clog2(MAX_OWED + 1);
  localparam int SW         = $clog2(max2(RFC_CYC, RP_CYC) + 1);
  localparam int UW         = $clog2(PWR_CYC + 1);

  st_t           state_q, state_d, after_gap;
  logic          tmr_ld;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic          tmr_last;
  logic          due;
  logic [CW-1:0] owed;
  logic          owed_full, owed_any;

  // named events
  logic ref_issue, pre_issue, sre_issue, pwr_done, cnt_en, in_srx;
  assign ref_issue = (state_q == ST_REF);
  assign pre_issue = (state_q == ST_PRE);
  assign sre_issue = (state_q == ST_SRE);
  assign in_srx    = (state_q == ST_SRX);
  assign pwr_done  = (state_q == ST_PWR) && tmr_last;
  assign cnt_en    = !clock_stopped(state_q);
  assign owed_any  = (owed != '0);

  refsched_tick #(.DIV(TICK_DIV), .TICKS(REFI_TICKS)) u_tick (
    .clk (clk), .rst_n (rst_n), .en (cnt_en), .due (due)
  );

  refsched_credit #(.MAXC(MAX_OWED)) u_credit (
    .clk (clk), .rst_n (rst_n), .earn (due), .spend (ref_issue),
    .wipe (sre_issue), .seed (pwr_done), .owed (owed), .full (owed_full)
  );

  refsched_timer #(.W(TW), .RST_VAL(PWR_CYC)) u_timer (
    .clk (clk), .rst_n (rst_n), .ld (tmr_ld), .ld_val (tmr_val),
    .cnt (tmr_cnt), .last (tmr_last)
  );

  // what follows a finished wait: pay debt, then sleep, else release
  always_comb begin
    if (owed_any)    after_gap = ST_REF;
    else if (sr_req) after_gap = ST_SRE;
    else             after_gap = ST_IDLE;
  end

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    case (state_q)
      ST_PWR:  if (tmr_last) state_d = ST_REQ;
      ST_IDLE: if (owed_any || sr_req) state_d = ST_REQ;
      ST_REQ:  if (arb_gnt) state_d = banks_idle ? after_gap : ST_PRE;
      ST_PRE: begin
        state_d = ST_PREW;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RP_CYC - 1);
      end
      ST_PREW: if (tmr_last) state_d = after_gap;
      ST_REF: begin
        state_d = ST_RFC;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RFC_CYC - 1);
      end
      ST_RFC:  if (tmr_last) state_d = after_gap;
      ST_SRE:  state_d = ST_SR;
      ST_SR: if (!sr_req) begin
        state_d = ST_SRX;
        tmr_ld  = 1'b1;
        tmr_val = TW'(RD_CYC);
      end
      ST_SRX:  if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWR;
    else        state_q <= state_d;
  end

  assign cmd_code   = cmd_of(state_q);
  assign cke        = !clock_stopped(state_q);
  assign arb_req    = owns_bus(state_q);
  assign arb_force  = owed_full;
  assign busy       = hard_hold(state_q) ||
                      (in_srx && (tmr_cnt > TW'(RD_CYC - SRX_NONRD_CYC)));
  assign rd_blocked = busy || in_srx;

  // ---------------- checks ----------------
  logic [SW-1:0] since_ref, since_pre;
  logic [UW-1:0] up_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref <= SW'(RFC_CYC);
      since_pre <= SW'(RP_CYC);
      up_cyc    <= '0;
    end else begin
      if (ref_issue)                     since_ref <= SW'(1);
      else if (since_ref < SW'(RFC_CYC)) since_ref <= since_ref + 1'b1;
      if (pre_issue)                     since_pre <= SW'(1);
      else if (since_pre < SW'(RP_CYC))  since_pre <= since_pre + 1'b1;
      if (up_cyc < UW'(PWR_CYC))         up_cyc <= up_cyc + 1'b1;
    end
  end

  // R6
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> (since_ref >= SW'(RFC_CYC)));

  // R5
  pre_to_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> (since_pre >= SW'(RP_CYC)));

  // R4
  cmd_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != 2'd0) |-> arb_gnt);

  // R1
  pwrup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> (up_cyc >= UW'(PWR_CYC)));

  // R8
  sre_banks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sre_issue || ref_issue) |-> banks_idle);

  // R9
  cke_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> cke);

  // R9
  cke_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |=> !cke);

endmodule

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  timeunit 1ns;
  timeprecision 1ps;

  // bench-side timing, from 20 ns clock
  localparam int PWR   = 200000 / 20;      // 200 us
  localparam int RFC   = (72 + 19) / 20;   // 72 ns rounded up
  localparam int RP    = 2;                // 18 ns -> 1, floor of 2
  localparam int PER   = 10 * (7800 / 200);
  localparam int NONRD = 12;
  localparam int RD    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_gnt = 1'b0;
  logic banks_idle = 1'b1;
  logic sr_req = 1'b0;
  logic arb_req, arb_force, cke, busy, rd_blocked;
  logic [1:0] cmd_code;

  dram_refresh_sched u0 (
    .clk (clk), .rst_n (rst_n), .arb_gnt (arb_gnt), .banks_idle (banks_idle),
    .sr_req (sr_req), .arb_req (arb_req), .arb_force (arb_force),
    .cmd_code (cmd_code), .cke (cke), .busy (busy), .rd_blocked (rd_blocked)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int n_chk = 0;
  int n_bad = 0;
  int exp_cyc[$];
  int exp_code[$];
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_cmd(int at_cyc, int code);
    exp_cyc.push_back(at_cyc);
    exp_code.push_back(code);
  endtask

  task automatic at(int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every command is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && cmd_code != 2'd0) begin
      check("R4 grant held during command", int'(arb_gnt), 1);
      if (exp_cyc.size() == 0) begin
        check("R4 unexpected command", int'(cmd_code), 0);
      end else begin
        int ec, ek;
        ec = exp_cyc.pop_front();
        ek = exp_code.pop_front();
        check("R5 R6 R8 command code", int'(cmd_code), ek);
        check("R5 R6 R8 command cycle", cyc, ec);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cke", int'(cke), 0);
    check("R1 reset busy", int'(busy), 1);
    check("R1 reset rd_blocked", int'(rd_blocked), 1);
    check("R1 reset command", int'(cmd_code), 0);
    check("R1 reset arb_req", int'(arb_req), 0);
    rst_n = 1'b1;

    at(PWR - 1);
    check("R1 cke still low", int'(cke), 0);
    at(PWR);
    check("R1 cke rise", int'(cke), 1);
    check("R2 first refresh request", int'(arb_req), 1);
    check("R11 busy low while requesting", int'(busy), 0);

    // first refresh, banks idle
    expect_cmd(PWR + 6, 2);
    at(PWR + 5);
    arb_gnt = 1'b1;
    at(PWR + 7);
    check("R11 busy during refresh", int'(busy), 1);
    at(PWR + 6 + RFC);
    check("R11 busy released", int'(busy), 0);
    check("R6 request dropped", int'(arb_req), 0);
    arb_gnt = 1'b0;

    // postponed credit
    at(PWR + PER);
    check("R3 no request before due seen", int'(arb_req), 0);
    at(PWR + PER + 1);
    check("R3 request after due", int'(arb_req), 1);
    check("R11 busy low while waiting", int'(busy), 0);
    at(PWR + 8 * PER - 20);
    banks_idle = 1'b0;
    at(PWR + 8 * PER - 1);
    check("R7 force low at seven", int'(arb_force), 0);
    at(PWR + 8 * PER);
    check("R7 force high at eight", int'(arb_force), 1);
    expect_cmd(PWR + 8 * PER + 6, 1);
    for (int k = 0; k < 8; k++) expect_cmd(PWR + 8 * PER + 6 + RP + k * RFC, 2);
    at(PWR + 8 * PER + 5);
    arb_gnt = 1'b1;
    at(PWR + 8 * PER + 6);
    banks_idle = 1'b1;   // precharge closes the banks
    at(PWR + 8 * PER + 6 + RP + 1);
    check("R7 force low after one paid", int'(arb_force), 0);
    at(PWR + 8 * PER + 6 + RP + 7 * RFC + RFC);
    check("R6 request dropped after burst", int'(arb_req), 0);
    arb_gnt = 1'b0;

    // self-refresh
    at(PWR + 9 * PER + 1);
    check("R3 ninth due request", int'(arb_req), 1);
    expect_cmd(PWR + 9 * PER + 6, 2);
    expect_cmd(PWR + 9 * PER + 6 + RFC, 3);
    at(PWR + 9 * PER + 5);
    sr_req  = 1'b1;
    arb_gnt = 1'b1;
    at(PWR + 9 * PER + 6 + RFC);
    check("R8 cke low at entry", int'(cke), 0);
    at(PWR + 9 * PER + 7 + RFC);
    check("R9 cke held low", int'(cke), 0);
    at(13600);
    check("R8 cke low in self-refresh", int'(cke), 0);
    sr_req = 1'b0;
    at(13601);
    check("R10 cke rise on exit", int'(cke), 1);
    check("R10 busy right after exit", int'(busy), 1);
    check("R10 no request during exit", int'(arb_req), 0);
    arb_gnt = 1'b0;
    at(13601 + NONRD - 1);
    check("R10 busy before non-read delay", int'(busy), 1);
    at(13601 + NONRD);
    check("R10 busy after non-read delay", int'(busy), 0);
    check("R10 reads still blocked", int'(rd_blocked), 1);
    at(13601 + RD - 1);
    check("R10 reads blocked before read delay", int'(rd_blocked), 1);
    at(13601 + RD);
    check("R10 reads released", int'(rd_blocked), 0);
    at(13601 + RD + 9);
    check("R8 credit cleared by entry", int'(arb_req), 0);
    at(13601 + PER - 1);
    check("R3 interval restarted", int'(arb_req), 0);
    at(13601 + PER + 1);
    check("R3 due after restart", int'(arb_req), 1);
    expect_cmd(13601 + PER + 5, 2);
    at(13601 + PER + 4);
    arb_gnt = 1'b1;
    at(13601 + PER + 5 + RFC);
    check("R6 request dropped", int'(arb_req), 0);
    arb_gnt = 1'b0;
    at(13601 + PER + 20);
    check("R4 leftover expected commands", exp_cyc.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: R4 run did not complete, actual %0d expected %0d", cyc, 14100);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule